// File: doc/BRIEF.md
# Two-Level ALU Control with 32-bit ALU

This block turns a 2-bit operation class, supplied by a processor's main control, and the 6-bit function field of a register-format instruction into a 3-bit internal ALU operation, then applies that operation to two operands. The class alone fixes the operation for memory-address and branch-compare work. Only the register-format class consults the function field.

The internal operation code packs the datapath controls directly. Bit 2 means "invert B and carry in one". Bits 1:0 pick the output source: 00 AND, 01 OR, 10 adder, 11 signed less-than. The legal codes are therefore 000 AND, 001 OR, 010 add, 110 subtract and 111 set-on-less-than. The result, a zero flag for branch decisions and a signed overflow flag for exception logic are captured in an output register. Each output therefore reflects the inputs present at the previous rising clock edge.

Top module: `alu_ctl_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `result` = 0, `zero` = 1 and `overflow` = 0.
- R2: Outputs are registered. `result`, `zero` and `overflow` reflect the inputs sampled at the preceding rising edge of `clk`.
- R3: Class 2'b00 performs A + B whatever the function field holds.
- R4: Class 2'b01 performs A − B whatever the function field holds.
- R5: Class 2'b10 decodes the function field: 6'b100000 add, 6'b100010 subtract, 6'b100100 AND, 6'b100101 OR, 6'b101010 set-on-less-than.
- R6: Under class 2'b10, any other function value performs an add.
- R7: Class 2'b11 performs an add.
- R8: Set-on-less-than gives 1 in bit 0 when A < B as signed two's-complement numbers, and stays correct when A − B overflows. All other result bits are 0.
- R9: `zero` is 1 exactly when `result` is all zeros.
- R10: `overflow` is 1 only for add or subtract, and only when the signed result's sign contradicts the operand signs. It is 0 for AND, OR and set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_class | input | 2 | Operation class from main control |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Registered ALU result |
| zero | output | 1 | Registered all-zero flag of the result |
| overflow | output | 1 | Registered signed overflow flag |

## Verification
The zero flag and the overflow flag can rise in the same cycle. Adding 0x80000000 to itself wraps to zero while overflowing. Subtracting 0x80000000 from itself gives zero with no overflow, and the bench checks both flags against its own arithmetic model. The less-than path is driven with operand pairs whose difference overflows, such as 0x80000000 against 1. The result must stay correct while `overflow` remains low, which confirms that the two functions share the subtractor without sharing the flag.

// File: rtl/alu_ctl_pkg.sv
// Package: shared operation encodings for the two-level ALU control.
// Assumes: op bit 2 = invert B and carry in 1; bits 1:0 pick the output source.
package alu_ctl_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM  = 2'b00,
        CLS_BR   = 2'b01,
        CLS_REG  = 2'b10,
        CLS_RSVD = 2'b11
    } alu_cls_e;

    localparam logic [1:0] SRC_AND = 2'b00;
    localparam logic [1:0] SRC_OR  = 2'b01;
    localparam logic [1:0] SRC_SUM = 2'b10;
    localparam logic [1:0] SRC_LT  = 2'b11;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_op_decode.sv
// Module: alu_op_decode
// Two-level decode. The class either fixes the operation or hands over to the
// function-field decoder. Purely combinational.
// Assumes: unknown function codes and the reserved class both fall back to add.
module alu_op_decode
    import alu_ctl_pkg::*;
#(
    parameter int FN_W = 6
) (
    input  logic [1:0]      alu_class,
    input  logic [FN_W-1:0] funct,
    output alu_op_e         op
);

    alu_op_e fixed_op;
    alu_op_e field_op;
    logic    use_field;

    // Level one: the class picks a fixed operation or defers to the field.
    always_comb begin
        use_field = 1'b0;
        fixed_op  = OP_ADD;
        unique case (alu_class)
            CLS_MEM:  fixed_op  = OP_ADD;
            CLS_BR:   fixed_op  = OP_SUB;
            CLS_REG:  use_field = 1'b1;
            default:  fixed_op  = OP_ADD;
        endcase
    end

    // Level two: the function field selects among the register operations.
    always_comb begin
        case (funct)
            FN_ADD:  field_op = OP_ADD;
            FN_SUB:  field_op = OP_SUB;
            FN_AND:  field_op = OP_AND;
            FN_OR:   field_op = OP_OR;
            FN_SLT:  field_op = OP_SLT;
            default: field_op = OP_ADD;
        endcase
    end

    // Final selection between the two levels.
    always_comb op = use_field ? field_op : fixed_op;

endmodule

// File: rtl/alu_core.sv
// Module: alu_core
// A shared adder with optional B inversion, bitwise logic and a signed
// less-than. Produces result, zero and overflow combinationally.
// Assumes: op follows alu_op_e. Overflow is reported only for the adder source
// of add and subtract.
module alu_core
    import alu_ctl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] or_v;
    logic             sum_ovf;
    logic             less;
    logic             negate;
    logic [1:0]       src;

    assign negate = op[2];
    assign src    = op[1:0];

    // Per-bit conditional inversion of B and the bitwise logic terms.
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign b_eff[gi] = b[gi] ^ negate;
            assign and_v[gi] = a[gi] & b[gi];
            assign or_v[gi]  = a[gi] | b[gi];
        end
    endgenerate

    // Shared adder with carry in tied to the invert control.
    always_comb sum = a + b_eff + {{(WIDTH-1){1'b0}}, negate};

    // Signed overflow from sign agreement, and the corrected less-than.
    always_comb begin
        sum_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        less    = sum[MSB] ^ sum_ovf;
    end

    // Output source selection.
    always_comb begin
        unique case (src)
            SRC_AND: y = and_v;
            SRC_OR:  y = or_v;
            SRC_SUM: y = sum;
            default: y = {{(WIDTH-1){1'b0}}, less};
        endcase
    end

    // Flags: all-zero detect and overflow gated to the adder source.
    always_comb begin
        zero = (y == '0);
        ovf  = sum_ovf && (src == SRC_SUM);
    end

endmodule

// File: rtl/alu_ctl_unit.sv
// Module: alu_ctl_unit (top)
// Two-level ALU control feeding a WIDTH-bit ALU, with outputs captured in a
// register stage.
// Assumes: synchronous active-low reset. Outputs lag the inputs by one clock.
module alu_ctl_unit
    import alu_ctl_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int FN_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       alu_class,
    input  logic [FN_W-1:0]  funct,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);

    alu_op_e          dec_op;
    logic [WIDTH-1:0] core_y;
    logic             core_zero;
    logic             core_ovf;

    alu_op_decode #(.FN_W(FN_W)) u_dec (
        .alu_class (alu_class),
        .funct     (funct),
        .op        (dec_op)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .op   (dec_op),
        .a    (opnd_a),
        .b    (opnd_b),
        .y    (core_y),
        .zero (core_zero),
        .ovf  (core_ovf)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            zero     <= 1'b1;
            overflow <= 1'b0;
        end else begin
            result   <= core_y;
            zero     <= core_zero;
            overflow <= core_ovf;
        end
    end

    // R1: reset state appears one edge after reset is seen.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && zero && !overflow));

    // R9: registered zero flag agrees with the registered result.
    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));

    // R3: memory class yields the sum of the previous operands.
    assert_mem_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alu_class) == CLS_MEM)
            |-> result == $past(opnd_a) + $past(opnd_b));

    // R4: branch class yields the difference of the previous operands.
    assert_br_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alu_class) == CLS_BR)
            |-> result == $past(opnd_a) - $past(opnd_b));

    // R8: less-than leaves every upper bit clear.
    assert_slt_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dec_op) == OP_SLT) |-> result[WIDTH-1:1] == '0);

    // R10: no overflow after a logic or less-than operation.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dec_op[1:0]) != SRC_SUM) |-> !overflow);

endmodule

// File: tb/alu_ctl_unit_tb.sv
// Directed bench: one task per scenario. Each task checks its own results
// against a model built from the requirements.
module alu_ctl_unit_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   alu_class = 2'b00;
    logic [5:0]   funct = 6'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         zero;
    logic         overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_ctl_unit #(.WIDTH(W), .FN_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .alu_class(alu_class), .funct(funct),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .zero(zero), .overflow(overflow)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Model: 0 and, 1 or, 2 add, 3 sub, 4 slt.
    function automatic int pick(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b01) return 3;
        if (c != 2'b10) return 2;
        case (f)
            6'b100010: return 3;
            6'b100100: return 0;
            6'b100101: return 1;
            6'b101010: return 4;
            default:   return 2;
        endcase
    endfunction

    // Drive one operation, wait one edge and check all three outputs.
    task automatic run_op(input string req, input logic [1:0] c, input logic [5:0] f,
                          input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] er;
        logic eo;
        int k;
        k = pick(c, f);
        eo = 1'b0;
        case (k)
            0: er = a & b;
            1: er = a | b;
            2: begin er = a + b; eo = (a[W-1] == b[W-1]) && (er[W-1] != a[W-1]); end
            3: begin er = a - b; eo = (a[W-1] != b[W-1]) && (er[W-1] != a[W-1]); end
            default: er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        @(negedge clk);
        alu_class = c; funct = f; opnd_a = a; opnd_b = b;
        @(negedge clk);
        chk(req, "result", result, er);
        chk(req, "zero", {31'd0, zero}, {31'd0, er == '0});
        chk(req, "overflow", {31'd0, overflow}, {31'd0, eo});
    endtask

    task automatic t_reset_R1();
        @(negedge clk);
        alu_class = 2'b00; opnd_a = 32'h5; opnd_b = 32'h7;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "result", result, '0);
        chk("R1", "zero", {31'd0, zero}, 32'd1);
        chk("R1", "overflow", {31'd0, overflow}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency_R2();
        @(negedge clk);
        alu_class = 2'b00; funct = 6'd0; opnd_a = 32'd10; opnd_b = 32'd20;
        @(posedge clk);
        #1 opnd_a = 32'd100;
        @(negedge clk);
        chk("R2", "result holds sampled value", result, 32'd30);
        @(negedge clk);
        chk("R2", "result after next edge", result, 32'd120);
    endtask

    task automatic t_mem_R3();
        run_op("R3", 2'b00, 6'b100100, 32'h0000_1000, 32'h0000_0024);
        run_op("R3", 2'b00, 6'b101010, 32'hFFFF_FFFC, 32'h0000_0010);
    endtask

    task automatic t_br_R4();
        run_op("R4", 2'b01, 6'b100101, 32'h1234_5678, 32'h1234_5678);
        run_op("R4", 2'b01, 6'b100000, 32'h0000_0003, 32'h0000_0009);
    endtask

    task automatic t_field_R5();
        run_op("R5", 2'b10, 6'b100000, 32'h7000_0000, 32'h0FFF_FFFF);
        run_op("R5", 2'b10, 6'b100010, 32'h0000_0010, 32'h0000_0011);
        run_op("R5", 2'b10, 6'b100100, 32'hF0F0_1234, 32'h0FF0_FF00);
        run_op("R5", 2'b10, 6'b100101, 32'hF000_0001, 32'h0000_1002);
        run_op("R5", 2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001);
    endtask

    task automatic t_default_R6();
        run_op("R6", 2'b10, 6'b000000, 32'h0000_00AA, 32'h0000_0055);
        run_op("R6", 2'b10, 6'b100011, 32'h0000_0100, 32'h0000_0001);
    endtask

    task automatic t_rsvd_R7();
        run_op("R7", 2'b11, 6'b100010, 32'h0000_0040, 32'h0000_0002);
    endtask

    task automatic t_slt_R8();
        run_op("R8", 2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001);
        run_op("R8", 2'b10, 6'b101010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        run_op("R8", 2'b10, 6'b101010, 32'h0000_0005, 32'h0000_0005);
    endtask

    task automatic t_zero_R9();
        run_op("R9", 2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555);
        run_op("R9", 2'b01, 6'b000000, 32'h8000_0000, 32'h8000_0000);
    endtask

    task automatic t_ovf_R10();
        run_op("R10", 2'b00, 6'b000000, 32'h8000_0000, 32'h8000_0000);
        run_op("R10", 2'b00, 6'b000000, 32'h7FFF_FFFF, 32'h0000_0001);
        run_op("R10", 2'b01, 6'b000000, 32'h8000_0000, 32'h0000_0001);
        run_op("R10", 2'b10, 6'b100101, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        t_reset_R1();
        t_latency_R2();
        t_mem_R3();
        t_br_R4();
        t_field_R5();
        t_default_R6();
        t_rsvd_R7();
        t_slt_R8();
        t_zero_R9();
        t_ovf_R10();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule